// File: doc/BRIEF.md
# Multiplexed-Address DRAM Device Decoder

This block is a clocked model of the control logic inside a dynamic RAM that takes a row address and a column address over the same pins. Each clock it samples active-low row strobe, column strobe and write-enable pins together with the shared address and a one-bit data input. It works out what kind of access is under way only from the order in which those strobes change. It latches the row when the row strobe falls. The column latch passes the address through while the column strobe is high and freezes when it falls. The block drives a one-bit data output with a separate enable.

A small parameterised bit array stands in for the cell array. It is indexed by the low bits of the latched row and column. Refresh is modelled as a report of the refreshed row. The row comes either from the external address or from an internal wrapping counter. A status port gives the decoded type of the current access so that a system model can follow the sequence. Access delay is one clock: every output is registered on the edge that samples the strobe change.

Top module: `dram_if_model`

## Requirements
- R1: After reset, `dout_oe` and `dout` are 0, `cyc_type` is 0 (idle) and `rfsh_row` is 0. The internal refresh counter starts at 0.
- R2: If the row strobe is first sampled low while the column strobe is already low and the output is off, the access is a counter refresh. `cyc_type` becomes 5, `rfsh_row` takes the counter value, the counter advances by one and the address pins are ignored.
- R3: If the row strobe is first sampled low while the column strobe is high, the row is latched, `cyc_type` becomes 4 and `rfsh_row` takes the low 9 address bits. The output stays off while the column strobe stays high.
- R4: The column used by an access is the address on the sample where the column strobe is first seen low. Address changes after that sample do not move the access.
- R5: If write-enable is low on the sample where the column strobe falls, the access is an early write. `cyc_type` becomes 2, the data input is stored at cell {row[2:0], col[2:0]}, and the output stays off for the whole access.
- R6: If write-enable is high on that sample, the access is a read. `cyc_type` becomes 1 and, after that edge, `dout_oe` is 1 with the stored bit on `dout`. Both hold while the column strobe stays low. The output is off on the edge that samples the column strobe high.
- R7: If write-enable falls while the column strobe is low during a read, `cyc_type` becomes 3 and the data input on that sample is stored at the latched row and column. The output keeps the bit read earlier until the column strobe rises.
- R8: If the column strobe is held low after a read while the row strobe rises and falls again, `cyc_type` becomes 6. The counter supplies and advances the refreshed row, and `dout_oe` and `dout` stay unchanged.
- R9: Several column-strobe pulses under one row-strobe low period each access a new column of the same latched row.
- R10: Whenever `dout_oe` is 0, `dout` is 0.
- R11: The refresh counter is 9 bits wide and wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| din | input | 1 | Data input |
| dout | output | 1 | Data output, 0 when not enabled |
| dout_oe | output | 1 | Output enable for the data pin |
| cyc_type | output | 3 | Decoded access type (0 idle, 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh, 6 hidden refresh) |
| rfsh_row | output | RFSH_W | Row most recently refreshed |

## Verification
A wrong row or column latch value shows at the ports one read later, as a wrong bit on `dout` the edge after the column strobe falls. A slipped refresh counter shows at once in `rfsh_row` on the next counter refresh. A mistaken classification shows in `cyc_type` on the very edge that samples the strobe change. The bench replays every pin change against a behavioural model and compares all outputs each clock, so any of these shows within a cycle of the stimulus that exposes it.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    CY_IDLE    = 3'd0,
    CY_READ    = 3'd1,
    CY_EWRITE  = 3'd2,
    CY_RMW     = 3'd3,
    CY_RASONLY = 3'd4,
    CY_CBR     = 3'd5,
    CY_HIDDEN  = 3'd6
  } cyc_e;
endpackage

// File: rtl/dram_pin_edges.sv
module dram_pin_edges #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '1;
    else        prev <= pin_n;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall[i] = prev[i] & ~pin_n[i];
    assign rise[i] = ~prev[i] & pin_n[i];
  end
endmodule

// File: rtl/dram_addr_latch.sv
module dram_addr_latch #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_load,
  input  logic              row_open,
  input  logic              cas_n,
  input  logic              cas_fall,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_now
);
  logic [ADDR_W-1:0] col_q;
  logic              col_pass;

  assign col_pass = (row_open | row_load) & (cas_n | cas_fall);
  assign col_now  = (row_open & cas_fall) ? addr : col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (row_load) row_q <= addr;
      if (col_pass) col_q <= addr;
    end
  end

  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_open && !cas_n && !cas_fall) |=> (col_q == $past(col_q))); // R4
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             rd_bit
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] cells;
  logic [IDX_W-1:0] idx;

  assign idx    = {row, col};
  assign rd_bit = cells[idx];

  always_ff @(posedge clk) begin
    if (!rst_n)     cells      <= '0;
    else if (wr_en) cells[idx] <= wr_bit;
  end

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cells[$past(idx)] == $past(wr_bit))); // R5
endmodule

// File: rtl/dram_cycle_ctl.sv
module dram_cycle_ctl
  import dram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RFSH_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_fall,
  input  logic              ras_rise,
  input  logic              cas_fall,
  input  logic              cas_rise,
  input  logic              we_fall,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_bit,
  output logic              row_load,
  output logic              row_open,
  output logic              wr_en,
  output logic              dout,
  output logic              dout_oe,
  output cyc_e              cyc_type,
  output logic [RFSH_W-1:0] rfsh_row
);
  logic [RFSH_W-1:0] rf_cnt;
  logic              rf_hit;
  logic              col_evt;
  logic              rmw_hit;

  assign row_load = ras_fall & cas_n;
  assign rf_hit   = ras_fall & ~cas_n;
  assign col_evt  = cas_fall & row_open;
  assign rmw_hit  = we_fall & ~cas_n & ~cas_fall & row_open & (cyc_type == CY_READ);
  assign wr_en    = (col_evt & ~we_n) | rmw_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      rf_cnt   <= '0;
      rfsh_row <= '0;
      cyc_type <= CY_IDLE;
      dout_oe  <= 1'b0;
      dout     <= 1'b0;
    end else begin
      if (rf_hit) begin
        cyc_type <= dout_oe ? CY_HIDDEN : CY_CBR;
        rfsh_row <= rf_cnt;
        rf_cnt   <= rf_cnt + 1'b1;
      end else if (row_load) begin
        row_open <= 1'b1;
        cyc_type <= CY_RASONLY;
        rfsh_row <= addr[RFSH_W-1:0];
      end
      if (ras_rise) row_open <= 1'b0;
      if (col_evt) begin
        if (!we_n) begin
          cyc_type <= CY_EWRITE;
          dout_oe  <= 1'b0;
          dout     <= 1'b0;
        end else begin
          cyc_type <= CY_READ;
          dout_oe  <= 1'b1;
          dout     <= rd_bit;
        end
      end
      if (cas_rise) begin
        dout_oe <= 1'b0;
        dout    <= 1'b0;
      end
      if (rmw_hit) cyc_type <= CY_RMW;
    end
  end

  AST_OE_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !$past(cas_n)); // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout); // R10
  AST_EW_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == CY_EWRITE) |-> !dout_oe); // R5
  AST_RASONLY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == CY_RASONLY) |-> !dout_oe); // R3
  AST_CBR_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    rf_hit |=> !row_open); // R2
  AST_HIDDEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_hit && dout_oe && !cas_rise) |=> (dout_oe && $stable(dout))); // R8
endmodule

// File: rtl/dram_if_model.sv
module dram_if_model
  import dram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int RFSH_W = 9,
  parameter int MROW_W = 3,
  parameter int MCOL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic [2:0]        cyc_type,
  output logic [RFSH_W-1:0] rfsh_row
);
  localparam int NPIN = 3;

  logic [NPIN-1:0]   fall, rise;
  logic [ADDR_W-1:0] row_q, col_now;
  logic              row_load, row_open, wr_en, rd_bit;
  cyc_e              ctype;

  dram_pin_edges #(.N(NPIN)) u_edges (
    .clk(clk), .rst_n(rst_n), .pin_n({we_n, cas_n, ras_n}),
    .fall(fall), .rise(rise)
  );

  dram_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .row_load(row_load), .row_open(row_open),
    .cas_n(cas_n), .cas_fall(fall[1]), .addr(addr),
    .row_q(row_q), .col_now(col_now)
  );

  dram_cell_array #(.ROW_W(MROW_W), .COL_W(MCOL_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(din),
    .row(row_q[MROW_W-1:0]), .col(col_now[MCOL_W-1:0]), .rd_bit(rd_bit)
  );

  dram_cycle_ctl #(.ADDR_W(ADDR_W), .RFSH_W(RFSH_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ras_fall(fall[0]), .ras_rise(rise[0]),
    .cas_fall(fall[1]), .cas_rise(rise[1]), .we_fall(fall[2]),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .rd_bit(rd_bit),
    .row_load(row_load), .row_open(row_open), .wr_en(wr_en),
    .dout(dout), .dout_oe(dout_oe), .cyc_type(ctype), .rfsh_row(rfsh_row)
  );

  assign cyc_type = ctype;
endmodule

// File: tb/sim_dram_if_model.sv
module sim_dram_if_model;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [9:0] addr = '0;
  logic       dout, dout_oe;
  logic [2:0] cyc_type;
  logic [8:0] rfsh_row;

  int n_run = 0, n_fail = 0;

  int m_cnt = 0, m_rfsh = 0, m_type = 0, m_row = 0, m_col = 0;
  bit m_oe = 0, m_dout = 0, m_open = 0;
  bit pr = 1, pc = 1, pw = 1;
  bit mem [64];

  always #4 clk = ~clk;

  dram_if_model u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .cyc_type(cyc_type), .rfsh_row(rfsh_row)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rf, rr, cf, cr, wf, open_b;
    int old_type;
    rf = pr && !ras_n;  rr = !pr && ras_n;
    cf = pc && !cas_n;  cr = !pc && cas_n;
    wf = pw && !we_n;
    open_b = m_open;
    old_type = m_type;
    if ((open_b || (rf && cas_n)) && (cas_n || cf)) m_col = int'(addr);
    if (rf) begin
      if (!cas_n) begin
        m_type = m_oe ? 6 : 5;
        m_rfsh = m_cnt;
        m_cnt  = (m_cnt + 1) % 512;
      end else begin
        m_row = int'(addr); m_rfsh = int'(addr) % 512; m_type = 4; m_open = 1;
      end
    end
    if (rr) m_open = 0;
    if (cf && open_b) begin
      if (!we_n) begin
        mem[(m_row % 8) * 8 + (m_col % 8)] = din;
        m_type = 2; m_oe = 0; m_dout = 0;
      end else begin
        m_type = 1; m_oe = 1; m_dout = mem[(m_row % 8) * 8 + (m_col % 8)];
      end
    end
    if (cr) begin m_oe = 0; m_dout = 0; end
    if (wf && !cas_n && !cf && open_b && old_type == 1) begin
      mem[(m_row % 8) * 8 + (m_col % 8)] = din;
      m_type = 3;
    end
    pr = ras_n; pc = cas_n; pw = we_n;
  endtask

  task automatic step(bit r, bit c, bit w, int a, bit d, string tag);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; addr = a[9:0]; din = d;
    @(posedge clk);
    model_step();
    #1;
    chk(tag, "dout_oe",  int'(dout_oe),  int'(m_oe));
    chk(tag, "dout",     int'(dout),     int'(m_dout));
    chk(tag, "cyc_type", int'(cyc_type), m_type);
    chk(tag, "rfsh_row", int'(rfsh_row), m_rfsh);
  endtask

  task automatic open_row(int row, string tag);
    step(1, 1, 1, row, 0, tag);
    step(0, 1, 1, row, 0, tag);
  endtask

  task automatic early_wr(int col, bit d, string tag);
    step(0, 1, 0, col, d, tag);
    step(0, 0, 0, col, d, tag);
    step(0, 0, 0, col + 3, ~d, tag);
    step(0, 1, 1, col, 0, tag);
  endtask

  task automatic rd(int col, string tag);
    step(0, 1, 1, col, 0, tag);
    step(0, 0, 1, col, 0, tag);
    step(0, 0, 1, col + 1, 0, tag);
    step(0, 0, 1, col + 2, 1, tag);
    step(0, 1, 1, col, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(1, 1, 1, 0, 0, "R1");

    // page of early writes in row 5
    open_row(5, "R3");
    early_wr(1, 1, "R5");
    early_wr(2, 0, "R9");
    early_wr(3, 1, "R9");
    early_wr(6, 1, "R5");
    step(1, 1, 1, 0, 0, "R9");

    // page of reads in row 5, output off after strobe rise
    open_row(5, "R3");
    rd(1, "R6");
    rd(2, "R10");
    rd(3, "R9");
    rd(6, "R6");
    step(1, 1, 1, 0, 0, "R6");

    // other row must not alias
    open_row(2, "R3");
    rd(1, "R9");
    step(1, 1, 1, 0, 0, "R9");

    // read-modify-write with address moved after column fall
    open_row(5, "R3");
    step(0, 1, 1, 2, 0, "R4");
    step(0, 0, 1, 2, 0, "R7");
    step(0, 0, 1, 7, 1, "R4");
    step(0, 0, 0, 7, 1, "R7");
    step(0, 0, 0, 7, 0, "R7");
    step(0, 1, 1, 7, 0, "R7");
    rd(2, "R4");
    rd(7, "R4");
    step(1, 1, 1, 0, 0, "R7");

    // row-only refresh, strobe stays high
    step(0, 1, 1, 'h1A3, 0, "R3");
    step(0, 1, 1, 'h0F0, 0, "R3");
    step(0, 1, 1, 'h0F0, 0, "R3");
    step(1, 1, 1, 0, 0, "R3");

    // counter refresh, address ignored
    step(1, 0, 1, 'h3FF, 0, "R2");
    step(0, 0, 1, 'h155, 0, "R2");
    step(0, 0, 1, 'h2AA, 0, "R2");
    step(1, 0, 1, 0, 0, "R2");
    step(0, 0, 1, 'h3FF, 0, "R2");
    step(1, 0, 1, 0, 0, "R2");
    step(1, 1, 1, 0, 0, "R10");

    // hidden refresh after a read
    open_row(5, "R8");
    step(0, 0, 1, 1, 0, "R8");
    step(1, 0, 1, 0, 0, "R8");
    step(0, 0, 1, 'h3C3, 0, "R8");
    step(0, 0, 1, 0, 0, "R8");
    step(1, 0, 1, 0, 0, "R8");
    step(1, 1, 1, 0, 0, "R8");

    // long run of counter refreshes to cross the wrap
    step(1, 0, 1, 0, 0, "R11");
    for (int i = 0; i < 520; i++) begin
      step(0, 0, 1, i, 0, "R11");
      step(1, 0, 1, i, 0, "R11");
    end
    step(1, 1, 1, 0, 0, "R11");

    // data intact after refresh traffic
    open_row(5, "R6");
    rd(1, "R6");
    rd(7, "R7");
    step(1, 1, 1, 0, 0, "R6");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule